// File: doc/BRIEF.md
# Floating-Point Compare Unit

This block compares two 64-bit IEEE-754 double-precision operands. It places the 2-bit ordering result into one of four condition-code fields of a 64-bit floating-point status register that the block holds. A strobe starts each compare. A 2-bit index picks the field that receives the result, and the other fields keep their values.

Two compare flavours are available. The quiet compare reports an unordered result for NaN operands and signals nothing. The signalling compare reports the same unordered result and also raises an invalid-operation flag whenever either operand is a NaN of any kind. All operand classes are handled: NaN, infinity, zero, normal and subnormal. Finite same-sign operands are ordered by an unsigned compare of their exponent-and-fraction bits.

Top module: `fcmp_unit`

## Requirements
- R1: If either operand is a NaN (exponent all ones, fraction nonzero), the selected field receives the unordered code 3.
- R2: After a signalling compare (`cmp_signal`=1), `invalid_q` is 1 exactly when an operand is a NaN. After a quiet compare (`cmp_signal`=0), `invalid_q` is 0.
- R3: Two zeros compare equal (code 0), whatever their signs.
- R4: If the signs differ and the pair is not two zeros, the negative operand is less. A negative zero counts as negative. Code 1 means a less than b, and code 2 means a greater than b.
- R5: With matching signs, magnitudes are ordered infinity > finite nonzero > zero. For two negative operands, less and greater swap.
- R6: Two infinities of the same sign compare equal.
- R7: Two finite nonzero operands of the same sign (normal or subnormal) are equal only when their bits are identical. Otherwise the larger value of bits 62:0 is the larger magnitude, with the swap for negatives.
- R8: `cc_sel` 0, 1, 2 and 3 write status bits [11:10], [33:32], [35:34] and [37:36]. The low bit of the code is at the lower position. No other status bit changes.
- R9: `fsr_q` and `invalid_q` change on the first rising clock edge after `cmp_valid` is sampled high, and not before that edge. Without `cmp_valid`, both hold their values.
- R10: During reset, and until the second rising edge after `rst_n` is released, `fsr_q` and `invalid_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| cmp_valid | input | 1 | Starts a compare in this cycle |
| cmp_signal | input | 1 | 1 = signalling compare, 0 = quiet compare |
| cc_sel | input | 2 | Index of the condition-code field to write |
| opa | input | 64 | First operand, raw double-precision bits |
| opb | input | 64 | Second operand, raw double-precision bits |
| fsr_q | output | 64 | Floating-point status register |
| invalid_q | output | 1 | Invalid-operation flag from the latest compare |

## Verification
The bench builds the block with its default parameters: an 11-bit exponent, a 52-bit fraction, a 64-bit status register and four 2-bit fields at the stated offsets. These values allow directed compares of every pairing of sign and operand class, including quiet and signalling NaNs, subnormals next to zero, and adjacent magnitudes. Writing all four field positions in sequence shows that the untouched fields keep their contents. A randomized phase mixes special encodings with random bits. Its expected codes come from mapping each operand to a signed integer key, which is not how the design orders its operands.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  // Ordering codes written into a condition-code field
  typedef enum logic [1:0] {
    CC_EQ = 2'd0,
    CC_LT = 2'd1,
    CC_GT = 2'd2,
    CC_UN = 2'd3
  } cc_e;

  // Operand class; numeric order of the three non-NaN values gives magnitude order
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_FIN  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } cls_e;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int MAG_W = EXP_W + FRAC_W,
  localparam int OP_W  = MAG_W + 1
) (
  input  logic [OP_W-1:0]  op,
  output logic             sign,
  output cls_e             cls,
  output logic [MAG_W-1:0] mag
);

  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic              exp_max;
  logic              exp_min;
  logic              frac_nz;

  assign sign    = op[OP_W-1];
  assign mag     = op[MAG_W-1:0];
  assign expo    = op[MAG_W-1:FRAC_W];
  assign frac    = op[FRAC_W-1:0];
  assign exp_max = &expo;
  assign exp_min = ~|expo;
  assign frac_nz = |frac;

  always_comb begin
    if (exp_max && frac_nz)       cls = CLS_NAN;
    else if (exp_max)             cls = CLS_INF;
    else if (exp_min && !frac_nz) cls = CLS_ZERO;
    else                          cls = CLS_FIN;
  end

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int MAG_W = 63
) (
  input  logic             sign_a,
  input  cls_e             cls_a,
  input  logic [MAG_W-1:0] mag_a,
  input  logic             sign_b,
  input  cls_e             cls_b,
  input  logic [MAG_W-1:0] mag_b,
  output cc_e              cc,
  output logic             any_nan
);

  logic mag_lt;
  logic mag_eq;
  logic both_zero;
  cc_e  mag_cc;

  assign any_nan   = (cls_a == CLS_NAN) || (cls_b == CLS_NAN);
  assign both_zero = (cls_a == CLS_ZERO) && (cls_b == CLS_ZERO);

  // Class rank first, then raw exponent/fraction bits within the same class
  assign mag_lt = (cls_a < cls_b) || ((cls_a == cls_b) && (mag_a < mag_b));
  assign mag_eq = (cls_a == cls_b) && (mag_a == mag_b);

  always_comb begin
    mag_cc = mag_lt ? CC_LT : CC_GT;
    if (sign_a) mag_cc = mag_lt ? CC_GT : CC_LT;
  end

  always_comb begin
    if (any_nan)              cc = CC_UN;
    else if (both_zero)       cc = CC_EQ;
    else if (sign_a != sign_b) cc = sign_a ? CC_LT : CC_GT;
    else if (mag_eq)          cc = CC_EQ;
    else                      cc = mag_cc;
  end

endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W    = 11,
  parameter int FRAC_W   = 52,
  parameter int FSR_W    = 64,
  parameter int FIELD_N  = 4,
  parameter int FIELD_W  = 2,
  parameter int LO_POS   = 10,
  parameter int HI_BASE  = 32,
  localparam int MAG_W   = EXP_W + FRAC_W,
  localparam int OP_W    = MAG_W + 1,
  localparam int SEL_W   = $clog2(FIELD_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_valid,
  input  logic             cmp_signal,
  input  logic [SEL_W-1:0] cc_sel,
  input  logic [OP_W-1:0]  opa,
  input  logic [OP_W-1:0]  opb,
  output logic [FSR_W-1:0] fsr_q,
  output logic             invalid_q
);

  // Reset synchronizer: asserts at once, releases on the second edge
  logic rst_meta_n;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // Operand classification
  logic             sign_a, sign_b;
  cls_e             cls_a, cls_b;
  logic [MAG_W-1:0] mag_a, mag_b;

  fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
    .op(opa), .sign(sign_a), .cls(cls_a), .mag(mag_a)
  );

  fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
    .op(opb), .sign(sign_b), .cls(cls_b), .mag(mag_b)
  );

  cc_e  cmp_cc;
  logic any_nan;

  fcmp_order #(.MAG_W(MAG_W)) u_order (
    .sign_a(sign_a), .cls_a(cls_a), .mag_a(mag_a),
    .sign_b(sign_b), .cls_b(cls_b), .mag_b(mag_b),
    .cc(cmp_cc), .any_nan(any_nan)
  );

  // Per-field masks, insert vectors and read-back views
  logic [FSR_W-1:0]   fld_mask [FIELD_N];
  logic [FSR_W-1:0]   fld_ins  [FIELD_N];
  logic [FIELD_W-1:0] fld_view [FIELD_N];

  for (genvar i = 0; i < FIELD_N; i++) begin : g_field
    localparam int POS = (i == 0) ? LO_POS : HI_BASE + (i - 1) * FIELD_W;
    assign fld_mask[i] = {{(FSR_W-FIELD_W){1'b0}}, {FIELD_W{1'b1}}} << POS;
    assign fld_ins[i]  = {{(FSR_W-FIELD_W){1'b0}}, cmp_cc} << POS;
    assign fld_view[i] = fsr_q[POS +: FIELD_W];
  end

  // Next-state logic
  logic [FSR_W-1:0] fsr_d;
  logic             inv_d;

  always_comb begin
    fsr_d = (fsr_q & ~fld_mask[cc_sel]) | fld_ins[cc_sel];
    inv_d = cmp_signal && any_nan;
  end

  // State registers with explicit enable
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      fsr_q     <= '0;
      invalid_q <= 1'b0;
    end else if (cmp_valid) begin
      fsr_q     <= fsr_d;
      invalid_q <= inv_d;
    end
  end

  // Assertions
  AST_NAN_UNORD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmp_valid && ((cls_a == CLS_NAN) || (cls_b == CLS_NAN)))
      |=> (fld_view[$past(cc_sel)] == CC_UN)); // R1

  AST_INV_FLAG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmp_valid |=> (invalid_q == $past(cmp_signal && ((cls_a == CLS_NAN) || (cls_b == CLS_NAN))))); // R2

  AST_ZERO_EQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmp_valid && (cls_a == CLS_ZERO) && (cls_b == CLS_ZERO))
      |=> (fld_view[$past(cc_sel)] == CC_EQ)); // R3

  AST_INF_EQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmp_valid && (cls_a == CLS_INF) && (cls_b == CLS_INF) && (sign_a == sign_b))
      |=> (fld_view[$past(cc_sel)] == CC_EQ)); // R6

  AST_KEEP_OTHERS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmp_valid |=> ((fsr_q & ~fld_mask[$past(cc_sel)]) == ($past(fsr_q) & ~fld_mask[$past(cc_sel)]))); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cmp_valid |=> ($stable(fsr_q) && $stable(invalid_q))); // R9

endmodule

// File: tb/fcmp_unit_test.sv
module fcmp_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmp_valid;
  logic        cmp_signal;
  logic [1:0]  cc_sel;
  logic [63:0] opa, opb;
  logic [63:0] fsr_q;
  logic        invalid_q;

  always #10 clk = ~clk; // 50 MHz

  fcmp_unit uut (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_signal(cmp_signal),
    .cc_sel(cc_sel), .opa(opa), .opb(opb), .fsr_q(fsr_q), .invalid_q(invalid_q)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [63:0] m_fsr;
  logic        m_inv;

  localparam logic [63:0] P_ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] N_ONE  = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] P_TWO  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] N_TWO  = 64'hC000_0000_0000_0000;
  localparam logic [63:0] P_INF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] N_INF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] Q_NAN  = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] S_NAN  = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] N_NAN  = 64'hFFF8_0000_0000_0005;
  localparam logic [63:0] P_ZERO = 64'h0000_0000_0000_0000;
  localparam logic [63:0] N_ZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] P_SUB1 = 64'h0000_0000_0000_0001;
  localparam logic [63:0] P_SUB2 = 64'h0000_0000_0000_0002;
  localparam logic [63:0] N_SUB1 = 64'h8000_0000_0000_0001;
  localparam logic [63:0] P_MAX  = 64'h7FEF_FFFF_FFFF_FFFF;
  localparam logic [63:0] N_MAX  = 64'hFFEF_FFFF_FFFF_FFFF;
  localparam logic [63:0] P_ONEU = 64'h3FF0_0000_0000_0001;

  function automatic bit is_nan(input logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
  endfunction

  // Signed integer key: monotone in the represented value, both zeros map to 0
  function automatic logic [1:0] ref_code(input logic [63:0] a, input logic [63:0] b);
    longint ka, kb;
    if (is_nan(a) || is_nan(b)) return 2'd3;
    ka = longint'({1'b0, a[62:0]});
    kb = longint'({1'b0, b[62:0]});
    if (a[63]) ka = -ka;
    if (b[63]) kb = -kb;
    if (ka < kb) return 2'd1;
    if (ka > kb) return 2'd2;
    return 2'd0;
  endfunction

  function automatic int field_lsb(input int idx);
    return (idx == 0) ? 10 : 30 + 2 * idx;
  endfunction

  task automatic check_state(input string req);
    checks++;
    if (fsr_q !== m_fsr || invalid_q !== m_inv) begin
      errors++;
      $display("FAIL %s: fsr=%h inv=%b expected fsr=%h inv=%b", req, fsr_q, invalid_q, m_fsr, m_inv);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic run(input bit v, input bit sig, input int sel,
                     input logic [63:0] a, input logic [63:0] b, input string req);
    int p;
    cmp_valid  = v;
    cmp_signal = sig;
    cc_sel     = 2'(sel);
    opa        = a;
    opb        = b;
    #1;
    check_state({req, " R9 before edge"});
    @(posedge clk);
    if (v) begin
      p = field_lsb(sel);
      m_fsr[p +: 2] = ref_code(a, b);
      m_inv = sig && (is_nan(a) || is_nan(b));
    end
    @(negedge clk);
    check_state(req);
  endtask

  function automatic logic [63:0] pick(input int k);
    logic [63:0] r;
    r = {$urandom, $urandom};
    case (k % 8)
      0: r = P_ZERO;
      1: r = N_ZERO;
      2: r = {r[63], 11'h7FF, 52'h0};
      3: r = {r[63], 11'h7FF, r[51:1], 1'b1};
      4: r = {r[63], 11'h000, r[51:0]};
      5: r = {r[63], 11'h3FF, r[51:2], 2'b00};
      default: ;
    endcase
    return r;
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: cycles=%0d expected completion", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; cmp_valid = 1'b1; cmp_signal = 1'b1; cc_sel = 2'd0;
    opa = Q_NAN; opb = P_ONE;
    m_fsr = '0; m_inv = 1'b0;
    repeat (3) @(negedge clk);
    check_state("R10 in reset with strobe active");
    cmp_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R10 after release");
    repeat (2) @(negedge clk);
    check_state("R10 settled");

    // R1 / R2 NaN handling
    run(1, 0, 0, Q_NAN, P_ONE, "R1 quiet qnan");
    run(1, 1, 1, P_ONE, S_NAN, "R2 signalling snan");
    run(1, 0, 2, S_NAN, S_NAN, "R2 quiet snan no flag");
    run(1, 1, 3, N_NAN, N_INF, "R1 R2 neg nan signalling");
    run(1, 1, 3, P_ONE, P_TWO, "R2 signalling ordered clears flag");
    // R3 zeros
    run(1, 0, 0, P_ZERO, N_ZERO, "R3 +0 vs -0");
    run(1, 1, 1, N_ZERO, N_ZERO, "R3 -0 vs -0");
    // R4 sign split
    run(1, 0, 2, N_ZERO, P_SUB1, "R4 -0 vs +sub");
    run(1, 0, 3, P_ZERO, N_SUB1, "R4 +0 vs -sub");
    run(1, 0, 0, N_INF, P_ZERO, "R4 -inf vs +0");
    run(1, 0, 1, P_ONE, N_MAX, "R4 +1 vs -max");
    // R5 class order
    run(1, 0, 2, P_INF, P_MAX, "R5 +inf vs +max");
    run(1, 0, 3, N_INF, N_MAX, "R5 -inf vs -max");
    run(1, 0, 0, P_ZERO, P_SUB1, "R5 +0 vs +sub");
    run(1, 0, 1, N_SUB1, N_ZERO, "R5 -sub vs -0");
    // R6 infinities
    run(1, 0, 2, P_INF, P_INF, "R6 +inf eq");
    run(1, 0, 3, N_INF, N_INF, "R6 -inf eq");
    // R7 finite magnitudes
    run(1, 0, 0, P_ONE, P_ONE, "R7 equal");
    run(1, 0, 1, P_ONE, P_ONEU, "R7 adjacent pos");
    run(1, 0, 2, N_ONE, 64'hBFF0_0000_0000_0001, "R7 adjacent neg");
    run(1, 0, 3, P_SUB2, P_SUB1, "R7 subnormals");
    run(1, 0, 0, N_TWO, N_ONE, "R7 neg larger mag is less");
    // R8 each field keeps the others
    run(1, 0, 0, Q_NAN, Q_NAN, "R8 field0");
    run(1, 0, 1, P_TWO, P_ONE, "R8 field1");
    run(1, 0, 2, P_ONE, P_TWO, "R8 field2");
    run(1, 0, 3, P_ZERO, N_ZERO, "R8 field3");
    // R9 idle holds
    run(0, 1, 1, Q_NAN, Q_NAN, "R9 idle nan");
    run(0, 0, 3, P_ONE, P_TWO, "R9 idle ordered");
    run(1, 1, 2, S_NAN, P_ONE, "R9 flag set");
    run(0, 0, 2, P_ONE, P_ONE, "R9 flag holds");
    // Randomized mix
    for (int i = 0; i < 400; i++) begin
      run(($urandom % 4) != 0, $urandom % 2, $urandom % 4,
          pick($urandom), pick($urandom), "R7 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule